// File: doc/BRIEF.md
# Index-Addressed Interrupt Controller

This block collects a vector of level-sensitive interrupt sources and presents them to a small set of CPUs. Each source carries a global enable bit, a per-CPU mask bit and a routing word that names the CPUs allowed to receive it. Software never rewrites whole bitmaps. It writes a source index to a set register or a clear register, and the block changes the single bit that index selects. A CPU is interrupted while at least one source qualifies for it: the input is high, the source is enabled, it is unmasked for that CPU and it is routed to that CPU.

Each CPU reads an acknowledge register to learn which source to service. The register returns the lowest-numbered source that qualifies for that CPU, or a reserved idle code when none does. The read changes no state. Because two CPUs could otherwise claim the same source, software is expected to route each source to one CPU only. Sources 0 and 1 are normally given to the inter-processor doorbell and the message-signalled summary. The block itself treats them like any other source. A shared register bus carries all accesses, and a CPU-select input tells the block which CPU is making each access.

Top module: `idx_irq_ctrl`

## Requirements
- R1: After reset every source is disabled, every source is masked for every CPU, every routing word reads 0, `irq_o` is 0 and `rdata_o` is 0.
- R2: A write of index i (in `wdata_i`) to offset 0x30 sets the global enable of source i, and a write to offset 0x34 clears it. The change applies to all CPUs, whichever CPU performs the write.
- R3: A write of index i to offset 0x48 masks source i for the CPU given by `cpu_i`, and a write to offset 0x4C unmasks it. The mask bits of the other CPUs do not change.
- R4: The routing word of source s is at offset 0x100 + 4·s. Bit c of that word lets CPU c receive the source. The word reads back with all higher bits 0.
- R5: A read of offset 0x44 returns, in bits [9:0], the lowest-numbered source that qualifies for CPU `cpu_i`, with bits [31:10] equal to 0. When no source qualifies, it returns 1023.
- R6: `irq_o[c]` is 1 exactly while at least one source qualifies for CPU c.
- R7: A read of offset 0x00 returns the number of sources in bits [11:2], with all other bits 0.
- R8: A set or clear write whose index is N_SRC or larger changes no state. In particular, the index is not truncated to fewer bits.
- R9: A read of the acknowledge register has no side effect, so back-to-back reads return the same ID.
- R10: Sources are level-sensitive. When a source input falls, the source stops qualifying at once, with no latched pending state.
- R11: `rdata_o` is loaded on the clock edge at which `re_i` is 1 and holds its value while `re_i` is 0. An unmapped offset reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_i | input | CPU_W | Index of the CPU making the bus access |
| addr_i | input | ADDR_W | Byte offset of the register |
| wdata_i | input | 32 | Write data (a source index or a routing word) |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Read data, valid the cycle after `re_i` |
| src_i | input | N_SRC | Level-sensitive interrupt source inputs |
| irq_o | output | N_CPU | Interrupt request to each CPU |

## Verification
A wrong enable, mask or routing bit shows up in the same cycle on `irq_o` of the affected CPU, and one cycle later as a wrong ID on the next acknowledge read from that CPU. A fault in the priority order or in the index decoding appears as a wrong ID when two qualifying sources are present together, or when an out-of-range index is written. Both cases are staged on purpose. A latched or sticky source shows up as an IRQ or an ID that persists after the input falls. The bench checks this in the cycle right after the input drops.

// File: rtl/idx_irq_pkg.sv
package idx_irq_pkg;
  localparam int unsigned ID_W = 10;
  localparam logic [ID_W-1:0] ID_IDLE = 10'd1023;

  localparam int unsigned OFS_CTRL    = 'h000;
  localparam int unsigned OFS_EN_SET  = 'h030;
  localparam int unsigned OFS_EN_CLR  = 'h034;
  localparam int unsigned OFS_ACK     = 'h044;
  localparam int unsigned OFS_MSK_SET = 'h048;
  localparam int unsigned OFS_MSK_CLR = 'h04C;
  localparam int unsigned OFS_ROUTE   = 'h100;

  typedef enum logic [1:0] {
    OP_NONE,
    OP_SET,
    OP_CLR
  } bit_op_e;
endpackage

// File: rtl/idx_irq_src_state.sv
module idx_irq_src_state
  import idx_irq_pkg::*;
#(
  parameter int unsigned N_SRC = 32,
  parameter int unsigned N_CPU = 2,
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  bit_op_e          en_op_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             route_we_i,
  input  logic [IDX_W-1:0] route_idx_i,
  input  logic [N_CPU-1:0] route_data_i,
  output logic [N_SRC-1:0] en_o,
  output logic [N_CPU-1:0] route_o [N_SRC]
);

  logic [N_SRC-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0;
    end else begin
      case (en_op_i)
        OP_SET:  en_q[idx_i] <= 1'b1;
        OP_CLR:  en_q[idx_i] <= 1'b0;
        default: ;
      endcase
    end
  end

  for (genvar s = 0; s < N_SRC; s++) begin : g_route
    logic [N_CPU-1:0] route_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        route_q <= '0;
      end else if (route_we_i && (route_idx_i == IDX_W'(s))) begin
        route_q <= route_data_i;
      end
    end
    assign route_o[s] = route_q;
  end

  assign en_o = en_q;

endmodule

// File: rtl/idx_irq_cpu_port.sv
module idx_irq_cpu_port
  import idx_irq_pkg::*;
#(
  parameter int unsigned N_SRC = 32,
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  bit_op_e          msk_op_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [N_SRC-1:0] src_i,
  input  logic [N_SRC-1:0] en_i,
  input  logic [N_SRC-1:0] routed_i,
  output logic             irq_o,
  output logic [ID_W-1:0]  ack_id_o
);

  logic [N_SRC-1:0] msk_q;
  logic [N_SRC-1:0] qual;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msk_q <= '1;
    end else begin
      case (msk_op_i)
        OP_SET:  msk_q[idx_i] <= 1'b1;
        OP_CLR:  msk_q[idx_i] <= 1'b0;
        default: ;
      endcase
    end
  end

  assign qual = src_i & en_i & ~msk_q & routed_i;

  // Lowest index wins: scan downward so the last hit is the smallest.
  always_comb begin
    ack_id_o = ID_IDLE;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (qual[i]) ack_id_o = ID_W'(i);
    end
  end

  assign irq_o = |qual;

endmodule

// File: rtl/idx_irq_ctrl.sv
module idx_irq_ctrl
  import idx_irq_pkg::*;
#(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned N_CPU  = 2,
  parameter int unsigned ADDR_W = 12,
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int unsigned CPU_W = (N_CPU > 1) ? $clog2(N_CPU) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CPU_W-1:0]  cpu_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic              we_i,
  input  logic              re_i,
  output logic [31:0]       rdata_o,
  input  logic [N_SRC-1:0]  src_i,
  output logic [N_CPU-1:0]  irq_o
);

  logic [N_SRC-1:0]  en_q;
  logic [N_CPU-1:0]  route [N_SRC];
  logic [ID_W-1:0]   ack_id [N_CPU];
  logic              idx_ok;
  logic              cpu_ok;
  logic [IDX_W-1:0]  idx;
  bit_op_e           en_op;
  bit_op_e           msk_op;
  logic [ADDR_W-1:0] route_ofs;
  logic              route_hit;
  logic [IDX_W-1:0]  route_idx;
  logic [31:0]       rd_val;
  logic [31:0]       rdata_q;

  assign idx_ok = (wdata_i < 32'(N_SRC));
  assign cpu_ok = (int'(cpu_i) < N_CPU);
  assign idx    = wdata_i[IDX_W-1:0];

  always_comb begin
    en_op  = OP_NONE;
    msk_op = OP_NONE;
    if (we_i && idx_ok) begin
      if (addr_i == ADDR_W'(OFS_EN_SET))  en_op  = OP_SET;
      if (addr_i == ADDR_W'(OFS_EN_CLR))  en_op  = OP_CLR;
      if (addr_i == ADDR_W'(OFS_MSK_SET)) msk_op = OP_SET;
      if (addr_i == ADDR_W'(OFS_MSK_CLR)) msk_op = OP_CLR;
    end
  end

  assign route_ofs = addr_i - ADDR_W'(OFS_ROUTE);
  assign route_hit = (addr_i >= ADDR_W'(OFS_ROUTE)) &&
                     (route_ofs < ADDR_W'(4 * N_SRC)) &&
                     (addr_i[1:0] == 2'b00);
  assign route_idx = route_ofs[IDX_W+1:2];

  idx_irq_src_state #(
    .N_SRC(N_SRC),
    .N_CPU(N_CPU)
  ) u_src_state (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_op_i     (en_op),
    .idx_i       (idx),
    .route_we_i  (we_i && route_hit),
    .route_idx_i (route_idx),
    .route_data_i(wdata_i[N_CPU-1:0]),
    .en_o        (en_q),
    .route_o     (route)
  );

  for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
    logic [N_SRC-1:0] routed;
    bit_op_e          op_c;

    for (genvar s = 0; s < N_SRC; s++) begin : g_col
      assign routed[s] = route[s][c];
    end

    assign op_c = (cpu_ok && (cpu_i == CPU_W'(c))) ? msk_op : OP_NONE;

    idx_irq_cpu_port #(
      .N_SRC(N_SRC)
    ) u_port (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .msk_op_i(op_c),
      .idx_i   (idx),
      .src_i   (src_i),
      .en_i    (en_q),
      .routed_i(routed),
      .irq_o   (irq_o[c]),
      .ack_id_o(ack_id[c])
    );
  end

  always_comb begin
    rd_val = '0;
    if (addr_i == ADDR_W'(OFS_CTRL)) begin
      rd_val[11:2] = 10'(N_SRC);
    end else if (addr_i == ADDR_W'(OFS_ACK)) begin
      rd_val[ID_W-1:0] = cpu_ok ? ack_id[cpu_i] : ID_IDLE;
    end else if (route_hit) begin
      rd_val[N_CPU-1:0] = route[route_idx];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= rd_val;
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/idx_irq_ctrl_chk.sv
module idx_irq_ctrl_chk
  import idx_irq_pkg::*;
#(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned N_CPU  = 2,
  parameter int unsigned ADDR_W = 12,
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic              we_i,
  input logic              re_i,
  input logic [31:0]       rdata_o,
  input logic [N_SRC-1:0]  src_i,
  input logic [N_CPU-1:0]  irq_o,
  input logic [N_SRC-1:0]  en_q
);

  logic en_wr;
  logic in_range;
  logic [IDX_W-1:0] wr_idx;

  assign en_wr    = we_i && ((addr_i == ADDR_W'(OFS_EN_SET)) || (addr_i == ADDR_W'(OFS_EN_CLR)) ||
                             (addr_i == ADDR_W'(OFS_MSK_SET)) || (addr_i == ADDR_W'(OFS_MSK_CLR)));
  assign in_range = (wdata_i < 32'(N_SRC));
  assign wr_idx   = wdata_i[IDX_W-1:0];

  always @(posedge clk_i) begin
    if (!rst_ni) assert_reset_quiet_R1: assert (irq_o == '0);
  end

  assert_set_enable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(OFS_EN_SET) && in_range) |=> en_q[$past(wr_idx)]);

  assert_clr_enable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(OFS_EN_CLR) && in_range) |=> !en_q[$past(wr_idx)]);

  assert_no_source_no_irq_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == '0) |-> (irq_o == '0));

  assert_disabled_no_irq_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == '0) |-> (irq_o == '0));

  assert_bad_index_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_wr && !in_range) |=> $stable(en_q));

  assert_rdata_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));

endmodule

bind idx_irq_ctrl idx_irq_ctrl_chk #(
  .N_SRC (N_SRC),
  .N_CPU (N_CPU),
  .ADDR_W(ADDR_W)
) chk_i (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .addr_i (addr_i),
  .wdata_i(wdata_i),
  .we_i   (we_i),
  .re_i   (re_i),
  .rdata_o(rdata_o),
  .src_i  (src_i),
  .irq_o  (irq_o),
  .en_q   (en_q)
);

// File: tb/idx_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module idx_irq_ctrl_tb_top;
  localparam int unsigned N_SRC  = 32;
  localparam int unsigned N_CPU  = 2;
  localparam int unsigned ADDR_W = 12;
  localparam logic [31:0] IDLE   = 32'd1023;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [0:0]        cpu = '0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wdata = '0;
  logic              we = 1'b0;
  logic              re = 1'b0;
  logic [31:0]       rdata;
  logic [N_SRC-1:0]  src = '0;
  logic [N_CPU-1:0]  irq;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  idx_irq_ctrl #(.N_SRC(N_SRC), .N_CPU(N_CPU), .ADDR_W(ADDR_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cpu_i(cpu), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .re_i(re), .rdata_o(rdata), .src_i(src), .irq_o(irq)
  );

  // k: 0 write, 1 read and compare, 2 drive sources
  typedef struct packed {
    logic [1:0]  k;
    logic [0:0]  c;
    logic [11:0] a;
    logic [31:0] d;
    logic [31:0] e;
    logic [3:0]  r;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t TBL [NV] = '{
    '{2'd1, 1'b0, 12'h000, 32'd0,  32'h80, 4'd7},  // R7 source count
    '{2'd1, 1'b0, 12'h044, 32'd0,  IDLE,   4'd1},  // R1 idle after reset
    '{2'd2, 1'b0, 12'h000, 32'h30, 32'd0,  4'd0},  // sources 4,5 high
    '{2'd0, 1'b0, 12'h030, 32'd5,  32'd0,  4'd0},
    '{2'd0, 1'b0, 12'h114, 32'd1,  32'd0,  4'd0},
    '{2'd1, 1'b0, 12'h044, 32'd0,  IDLE,   4'd3},  // R3 masked at reset
    '{2'd0, 1'b0, 12'h04C, 32'd5,  32'd0,  4'd0},
    '{2'd1, 1'b0, 12'h044, 32'd0,  32'd5,  4'd5},  // R5
    '{2'd1, 1'b1, 12'h044, 32'd0,  IDLE,   4'd4},  // R4 not routed to cpu1
    '{2'd0, 1'b0, 12'h030, 32'd4,  32'd0,  4'd0},
    '{2'd0, 1'b0, 12'h110, 32'd1,  32'd0,  4'd0},
    '{2'd0, 1'b0, 12'h04C, 32'd4,  32'd0,  4'd0},
    '{2'd1, 1'b0, 12'h044, 32'd0,  32'd4,  4'd5},  // R5 lowest wins
    '{2'd0, 1'b1, 12'h034, 32'd4,  32'd0,  4'd0},
    '{2'd1, 1'b0, 12'h044, 32'd0,  32'd5,  4'd2},  // R2 global clear from cpu1
    '{2'd1, 1'b0, 12'h114, 32'd0,  32'd1,  4'd4},  // R4 readback
    '{2'd0, 1'b0, 12'h048, 32'd5,  32'd0,  4'd0},
    '{2'd1, 1'b0, 12'h044, 32'd0,  IDLE,   4'd3},  // R3 masked again
    '{2'd0, 1'b0, 12'h114, 32'd2,  32'd0,  4'd0},
    '{2'd0, 1'b1, 12'h04C, 32'd5,  32'd0,  4'd0},
    '{2'd1, 1'b1, 12'h044, 32'd0,  32'd5,  4'd4},  // R4 rerouted
    '{2'd1, 1'b1, 12'h044, 32'd0,  32'd5,  4'd9},  // R9 no side effect
    '{2'd0, 1'b0, 12'h034, 32'd37, 32'd0,  4'd0},
    '{2'd1, 1'b1, 12'h044, 32'd0,  32'd5,  4'd8},  // R8 index 37 ignored
    '{2'd1, 1'b0, 12'h200, 32'd0,  32'd0,  4'd11}, // R11 unmapped
    '{2'd1, 1'b0, 12'h044, 32'd0,  IDLE,   4'd3}   // R3 cpu0 still masked
  };

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [0:0] c, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    cpu = c; addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic bus_rd(input logic [0:0] c, input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    cpu = c; addr = a; re = 1'b1;
    @(negedge clk);
    re = 1'b0;
    d = rdata;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    check(1, 32'(irq), 32'd0);   // R1 irq low in reset
    check(1, rdata, 32'd0);      // R1 rdata cleared
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      case (TBL[i].k)
        2'd0: bus_wr(TBL[i].c, TBL[i].a, TBL[i].d);
        2'd1: begin
          bus_rd(TBL[i].c, TBL[i].a, v);
          check(int'(TBL[i].r), v, TBL[i].e);
        end
        default: begin
          @(negedge clk);
          src = TBL[i].d;
        end
      endcase
    end

    // R6 only source 5 qualifies, routed to cpu1
    @(negedge clk);
    check(6, 32'(irq), 32'h2);

    // R11 rdata holds with no read
    bus_rd(1'b1, 12'h044, v);
    repeat (3) @(negedge clk);
    check(11, rdata, 32'd5);

    // R10 level drop removes source immediately
    src = '0;
    #1;
    check(10, 32'(irq), 32'd0);
    bus_rd(1'b1, 12'h044, v);
    check(10, v, IDLE);

    // R6 reassert drives irq again in same cycle
    src = 32'h20;
    #1;
    check(6, 32'(irq), 32'h2);

    // R1 mid-run reset clears everything
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check(1, 32'(irq), 32'd0);
    bus_rd(1'b1, 12'h044, v);
    check(1, v, IDLE);
    bus_rd(1'b0, 12'h114, v);
    check(1, v, 32'd0);

    finish_run();
  end
endmodule